// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block walks one chip select of a DDR SDRAM through its power-up bring-up without software help. A single-cycle start pulse captures the chip-select index, a CAS-latency code, a big-memory enable and a two-bit bank qualifier. The block then issues eleven steps in a fixed order. The first step loads the mode register with the DLL reset bit set. Next come a clock-enable-only power-down release, a second power-down release with the chip select, a precharge, an extended-mode set, a mode set, another precharge and two auto-refreshes. The last steps reload the mode register with DLL reset cleared and issue a closing mode set.

Each step appears for exactly one cycle on a command strobe. The strobe carries a command code and a chip-select mask, and the mode and extended-mode values are held on their own outputs. A programmable gap of `WAIT_CYC` cycles separates consecutive steps. The default of 200,000 cycles gives 200 µs at 1 GHz, and a small value serves for fast simulation. When the final gap expires, `done_o` rises and stays high until the next start.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and after it until the first start, the strobe, clock-enable and done outputs are low and the mode and extended-mode outputs are zero.
- R2: After an accepted start, the strobed command codes follow this order: 1 (mode load, DLL reset), 2 (clear power-down), 2, 3 (precharge), 4 (EMRS), 5 (MRS), 3, 6 (auto-refresh), 6, 1 (mode load, DLL release), 5. Code 0 is never strobed.
- R3: The first strobe comes one cycle after the start is accepted. After each strobe come `WAIT_CYC` strobe-low cycles, with two exceptions: the second mode load is followed by its MRS in the very next cycle, and `done_o` rises at the `WAIT_CYC`-th clock edge after the final strobe.
- R4: Every strobe lasts exactly one cycle, and its code and mask are valid in that cycle.
- R5: On each mode load, `mode_o` takes the value burst length bits [2:0]=3'b010, bit 3=0 (sequential), bit 8 = DLL reset (1 on the first load, 0 on the second), all other bits 0. The CAS field [6:4] is 3'b011 for code 0 (CL3), 3'b110 for code 1 (CL2.5), 3'b010 for code 2 (CL2), 3'b101 for code 3 (CL1.5), and 3'b110 for any other code. At the same time, `emode_o` takes the `EMODE_VAL` parameter.
- R6: Both mode loads and the first clear-power-down carry an all-zero mask. Every other command has mask bit `cs_sel` set. In big-memory mode, the bank qualifier is also ORed onto mask bits [3:2] (qualifier bit 0 on mask bit 2).
- R7: `cke_o` stays low until the first clear-power-down strobe cycle, in which it is high. From then on it never falls.
- R8: A start that arrives while a sequence runs is ignored. `done_o` stays high until a start is accepted, and no strobe occurs while done is high. A start seen while done is high restarts the sequence, and done falls one cycle later.
- R9: The chip-select index, CAS code, big-memory enable and bank qualifier are captured at the accepted start. Changing them later has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| cs_sel_i | input | SEL_W | Chip-select index |
| cas_code_i | input | 3 | CAS-latency selector code |
| bigmem_i | input | 1 | Big-memory enable (bank qualifier on mask) |
| bank_q_i | input | 2 | Bank qualifier for big-memory mode |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_code_o | output | 3 | Command code |
| cs_mask_o | output | NUM_CS | Chip-select mask |
| cke_o | output | 1 | Memory clock enable |
| mode_o | output | MODE_W | Mode register value |
| emode_o | output | MODE_W | Extended-mode register value |
| done_o | output | 1 | Sequence finished |

## Verification
The bench builds the block with `WAIT_CYC` = 4 and `EMODE_VAL` = 13'h002, keeping `NUM_CS` = 4 and `MODE_W` = 13. A full sequence then takes under 60 cycles, so runs with every CAS code are cheap, including two codes that fall back, and runs with both big-memory settings and several chip selects. The small gap also makes it cheap to check the spacing of every strobe, the back-to-back pair and the moment done rises, cycle by cycle. It also allows start pulses and input changes to be injected both inside gaps and while done is held.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_LDMODE = 3'd1,
    CMD_CLRPD  = 3'd2,
    CMD_PRE    = 3'd3,
    CMD_EMRS   = 3'd4,
    CMD_MRS    = 3'd5,
    CMD_AR     = 3'd6
  } cmd_e;

  localparam int STEPS  = 11;
  localparam int STEP_W = 4;

  typedef struct packed {
    cmd_e code;
    logic use_cs;   // drive the decoded mask
    logic dll_rst;  // DLL reset bit for mode loads
    logic gap;      // wait after this step
  } step_t;

  function automatic step_t step_lut(input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{code: CMD_NOP, use_cs: 1'b0, dll_rst: 1'b0, gap: 1'b1};
    case (idx)
      4'd0:  s = '{code: CMD_LDMODE, use_cs: 1'b0, dll_rst: 1'b1, gap: 1'b1};
      4'd1:  s = '{code: CMD_CLRPD,  use_cs: 1'b0, dll_rst: 1'b0, gap: 1'b1};
      4'd2:  s = '{code: CMD_CLRPD,  use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      4'd3:  s = '{code: CMD_PRE,    use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      4'd4:  s = '{code: CMD_EMRS,   use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      4'd5:  s = '{code: CMD_MRS,    use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      4'd6:  s = '{code: CMD_PRE,    use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      4'd7:  s = '{code: CMD_AR,     use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      4'd8:  s = '{code: CMD_AR,     use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      4'd9:  s = '{code: CMD_LDMODE, use_cs: 1'b0, dll_rst: 1'b0, gap: 1'b0};
      4'd10: s = '{code: CMD_MRS,    use_cs: 1'b1, dll_rst: 1'b0, gap: 1'b1};
      default: s = '{code: CMD_NOP, use_cs: 1'b0, dll_rst: 1'b0, gap: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
  parameter int WAIT_CYC = 200000,
  localparam int CNT_W = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(WAIT_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == '0);

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < WAIT_CYC); // R3

endmodule

// File: rtl/ddr_init_mode_gen.sv
module ddr_init_mode_gen #(
  parameter int MODE_W = 13
) (
  input  logic [2:0]        cas_code_i,
  input  logic              dll_rst_i,
  output logic [MODE_W-1:0] mode_o
);

  logic [2:0] cas_fld;

  always_comb begin
    case (cas_code_i)
      3'd0:    cas_fld = 3'b011; // CL3
      3'd1:    cas_fld = 3'b110; // CL2.5
      3'd2:    cas_fld = 3'b010; // CL2
      3'd3:    cas_fld = 3'b101; // CL1.5
      default: cas_fld = 3'b110; // fallback CL2.5
    endcase
  end

  always_comb begin
    mode_o      = '0;
    mode_o[2:0] = 3'b010;  // burst of 4
    mode_o[3]   = 1'b0;    // sequential
    mode_o[6:4] = cas_fld;
    mode_o[8]   = dll_rst_i;
  end

endmodule

// File: rtl/ddr_init_cs_decode.sv
module ddr_init_cs_decode #(
  parameter int NUM_CS = 4,
  parameter int BQ_LSB = 2,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              big_i,
  input  logic [1:0]        bq_i,
  output logic [NUM_CS-1:0] mask_o
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_bit
    if (i >= BQ_LSB && i < BQ_LSB + 2) begin : g_qual
      assign mask_o[i] = (sel_i == SEL_W'(i)) | (big_i & bq_i[i-BQ_LSB]);
    end else begin : g_plain
      assign mask_o[i] = (sel_i == SEL_W'(i));
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int WAIT_CYC = 200000,
  parameter int MODE_W   = 13,
  parameter logic [MODE_W-1:0] EMODE_VAL = '0,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  cs_sel_i,
  input  logic [2:0]        cas_code_i,
  input  logic              bigmem_i,
  input  logic [1:0]        bank_q_i,
  output logic              cmd_vld_o,
  output logic [2:0]        cmd_code_o,
  output logic [NUM_CS-1:0] cs_mask_o,
  output logic              cke_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [MODE_W-1:0] emode_o,
  output logic              done_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP, ST_DONE} st_e;

  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic [SEL_W-1:0]  sel_q;
  logic [2:0]        cas_q;
  logic              big_q;
  logic [1:0]        bq_q;

  step_t             cur;
  logic [MODE_W-1:0] mode_val;
  logic [NUM_CS-1:0] dec_mask;
  logic              tmr_load;
  logic              tmr_expire;

  assign cur      = step_lut(step_q);
  assign tmr_load = (st_q == ST_RUN) && cur.gap;

  ddr_init_gap_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .expire_o (tmr_expire)
  );

  ddr_init_mode_gen #(.MODE_W(MODE_W)) u_mode (
    .cas_code_i (cas_q),
    .dll_rst_i  (cur.dll_rst),
    .mode_o     (mode_val)
  );

  ddr_init_cs_decode #(.NUM_CS(NUM_CS), .BQ_LSB(2)) u_dec (
    .sel_i  (sel_q),
    .big_i  (big_q),
    .bq_i   (bq_q),
    .mask_o (dec_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      step_q     <= '0;
      sel_q      <= '0;
      cas_q      <= '0;
      big_q      <= 1'b0;
      bq_q       <= '0;
      cmd_vld_o  <= 1'b0;
      cmd_code_o <= CMD_NOP;
      cs_mask_o  <= '0;
      cke_o      <= 1'b0;
      mode_o     <= '0;
      emode_o    <= '0;
      done_o     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: begin
          cmd_vld_o <= 1'b0;
          if (start_i) begin
            sel_q  <= cs_sel_i;
            cas_q  <= cas_code_i;
            big_q  <= bigmem_i;
            bq_q   <= bank_q_i;
            step_q <= '0;
            done_o <= 1'b0;
            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          cmd_vld_o  <= 1'b1;
          cmd_code_o <= cur.code;
          cs_mask_o  <= cur.use_cs ? dec_mask : '0;
          if (cur.code == CMD_LDMODE) begin
            mode_o  <= mode_val;
            emode_o <= EMODE_VAL;
          end
          if (cur.code == CMD_CLRPD) begin
            cke_o <= 1'b1;
          end
          if (cur.gap) begin
            st_q <= ST_GAP;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_GAP: begin
          cmd_vld_o <= 1'b0;
          if (tmr_expire) begin
            if (step_q == STEP_W'(STEPS - 1)) begin
              done_o <= 1'b1;
              st_q   <= ST_DONE;
            end else begin
              step_q <= step_q + 1'b1;
              st_q   <= ST_RUN;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_o && cmd_code_o != CMD_LDMODE) |=> !cmd_vld_o); // R4

  AST_RELEASE_THEN_MRS: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_o && cmd_code_o == CMD_LDMODE && !mode_o[8]) |=>
    (cmd_vld_o && cmd_code_o == CMD_MRS)); // R3

  AST_NO_NOP_STROBE: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |-> cmd_code_o != CMD_NOP); // R2

  AST_CKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o); // R7

  AST_CKE_BEFORE_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_o && (cmd_code_o == CMD_PRE || cmd_code_o == CMD_EMRS ||
                   cmd_code_o == CMD_MRS || cmd_code_o == CMD_AR)) |-> cke_o); // R7

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !cmd_vld_o); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o); // R8

  AST_MASK_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_o && !big_q && (cmd_code_o == CMD_PRE || cmd_code_o == CMD_MRS ||
                             cmd_code_o == CMD_AR || cmd_code_o == CMD_EMRS))
    |-> $countones(cs_mask_o) == 1); // R6

  AST_MODE_BURST: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_o && cmd_code_o == CMD_LDMODE) |-> mode_o[3:0] == 4'b0010); // R5

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

  localparam int WAITC = 4;
  localparam logic [12:0] EMV = 13'h002;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  sel;
  logic [2:0]  cas;
  logic        big;
  logic [1:0]  bq;
  logic        vld;
  logic [2:0]  code;
  logic [3:0]  mask;
  logic        cke;
  logic [12:0] mode;
  logic [12:0] emode;
  logic        done;

  always #10 clk = ~clk;

  ddr_init_seq #(.NUM_CS(4), .WAIT_CYC(WAITC), .MODE_W(13), .EMODE_VAL(EMV)) u_ddr_init_seq (
    .clk(clk), .rst(rst), .start_i(start), .cs_sel_i(sel), .cas_code_i(cas),
    .bigmem_i(big), .bank_q_i(bq), .cmd_vld_o(vld), .cmd_code_o(code),
    .cs_mask_o(mask), .cke_o(cke), .mode_o(mode), .emode_o(emode), .done_o(done)
  );

  typedef struct packed {
    logic        vld;
    logic [2:0]  code;
    logic [3:0]  mask;
    logic        setmode;
    logic [12:0] mode;
    logic        setcke;
    logic        done;
  } ent_t;

  ent_t        q[$];
  logic        e_vld, e_cke, e_done;
  logic [2:0]  e_code;
  logic [3:0]  e_mask;
  logic [12:0] e_mode, e_emode;
  int          total = 0;
  int          bad = 0;
  string       tag = "R1";

  function automatic logic [2:0] cas_field(input logic [2:0] c);
    case (c)
      3'd0: return 3'b011;
      3'd1: return 3'b110;
      3'd2: return 3'b010;
      3'd3: return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s [%s] act=%0h exp=%0h", req, what, tag, act, exp);
    end
  endtask

  task automatic build(input logic [1:0] s, input logic [2:0] c, input logic b,
                       input logic [1:0] k);
    int codes[11] = '{1, 2, 2, 3, 4, 5, 3, 6, 6, 1, 5};
    logic [3:0] m;
    ent_t e;
    m = 4'b0001 << s;
    if (b) m = m | {k, 2'b00};
    e = '0;
    q.push_back(e);                       // start accepted: quiet cycle
    for (int i = 0; i < 11; i++) begin
      e = '0;
      e.vld = 1'b1;
      e.code = 3'(codes[i]);
      e.mask = (i == 0 || i == 1 || i == 9) ? 4'b0000 : m;
      if (i == 0 || i == 9) begin
        e.setmode = 1'b1;
        e.mode = {4'b0, (i == 0), 1'b0, cas_field(c), 1'b0, 3'b010};
      end
      e.setcke = (i == 1);
      q.push_back(e);
      if (i == 10) begin
        for (int j = 0; j < WAITC - 1; j++) q.push_back(ent_t'(0));
        e = '0;
        e.done = 1'b1;
        q.push_back(e);
      end else if (i != 9) begin
        for (int j = 0; j < WAITC; j++) q.push_back(ent_t'(0));
      end
    end
  endtask

  // Reference model and comparison, away from the active edge
  always @(negedge clk) begin
    ent_t e;
    if (rst) begin
      q.delete();
      e_vld = 0; e_cke = 0; e_done = 0; e_code = 0; e_mask = 0;
      e_mode = 0; e_emode = 0;
      chk(vld == 1'b0 && cke == 1'b0 && done == 1'b0, "R1", "reset ctrl",
          {29'b0, vld, cke, done}, 0);
      chk(mode == 13'h0 && emode == 13'h0, "R1", "reset mode", {mode, emode}, 0);
    end else begin
      chk(vld == e_vld, "R3 R4", "strobe", vld, e_vld);
      if (e_vld) begin
        chk(code == e_code, "R2", "code", code, e_code);
        chk(mask == e_mask, "R6", "mask", mask, e_mask);
      end
      chk(cke == e_cke, "R7", "cke", cke, e_cke);
      chk(done == e_done, "R8", "done", done, e_done);
      chk(mode == e_mode, "R5", "mode", mode, e_mode);
      chk(emode == e_emode, "R5", "emode", emode, e_emode);
      if (q.size() == 0 && start) build(sel, cas, big, bq);
      if (q.size() > 0) begin
        e = q.pop_front();
        e_vld = e.vld;
        if (e.vld) begin
          e_code = e.code;
          e_mask = e.mask;
        end
        if (e.setmode) begin
          e_mode = e.mode;
          e_emode = EMV;
        end
        if (e.setcke) e_cke = 1'b1;
        e_done = e.done;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic kick(input logic [1:0] s, input logic [2:0] c, input logic b,
                      input logic [1:0] k);
    sel = s; cas = c; big = b; bq = k; start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(posedge clk);
    #2;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; sel = 0; cas = 0; big = 0; bq = 0;
    tick(3);
    rst = 1'b0;
    tag = "R1";
    tick(4);                               // idle after reset
    tag = "R2 R5 CL2.5";
    kick(2'd1, 3'd1, 1'b0, 2'b00);
    wait_done();
    tick(3);
    tag = "R8 R9 ignore";
    kick(2'd0, 3'd2, 1'b0, 2'b00);
    tick(7);
    sel = 2'd3; cas = 3'd0; big = 1'b1; bq = 2'b11;  // R9 changes mid-run
    start = 1'b1; tick(1); start = 1'b0;              // R8 start while running
    tick(20);
    start = 1'b1; tick(1); start = 1'b0;
    wait_done();
    tick(6);                                // R8 done held
    tag = "R6 bigmem CL3";
    kick(2'd3, 3'd0, 1'b1, 2'b01);
    wait_done();
    tag = "R6 bigmem CL1.5";
    kick(2'd0, 3'd3, 1'b1, 2'b11);
    wait_done();
    tick(2);
    tag = "R5 fallback5";
    kick(2'd2, 3'd5, 1'b0, 2'b11);
    wait_done();
    tag = "R5 fallback7";
    kick(2'd1, 3'd7, 1'b1, 2'b10);
    wait_done();
    tick(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule